// File: doc/BRIEF.md
# Sparse Accumulator CAM Merge Unit

This block is the merge engine of a sparse matrix-matrix multiply kernel. Each input beat carries an output row index and two operand values. The block forms their semiring product and folds it into an on-chip sparse accumulator, a small content-addressable memory. Every stored entry pairs a key (the row index) with a running value.

A lookup compares the index of a beat against every valid key at once.
- On a hit, the stored value is combined with the product and written back to the same slot.
- On a miss, the next free slot is claimed and takes the index and the product.

The write-back of one beat can be pending while the next beat looks up its index. That pending result is forwarded, so beats with the same index can arrive back to back.

Two semirings are offered, picked per beat by `in_minplus`:
- Multiply-accumulate: the product is `a*b` and the combine is `+`.
- Min-plus, for shortest-path kernels: the product is `a+b` and the combine is `min`.

A `flush` pulse ends an accumulation phase. After the pipeline empties, the block emits the stored (index, value) pairs in the order the slots were claimed. It then empties the accumulator for the next phase.

Both streams use valid/ready.
- Input: a beat transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on the phase of the block, never on `in_valid`.
- Output: `out_valid`, `out_idx`, `out_val` and `out_last` stay constant while `out_ready` is low. A pair transfers on an edge where `out_valid` and `out_ready` are both high.

Top module: `spa_cam_merge`

## Requirements
- R1: The product of a beat is `(in_a*in_b) mod 2^VAL_W` when `in_minplus`=0 and `(in_a+in_b) mod 2^VAL_W` when `in_minplus`=1.
- R2: A beat whose index is already stored updates that entry. The new value is `(old+product) mod 2^VAL_W` in mode 0 and the unsigned minimum of old and product in mode 1. Each index appears at most once in the drained stream.
- R3: A beat whose index is not stored claims the lowest unused slot. The drained stream lists indices in the order of their first accepted appearance.
- R4: Beats with the same index on consecutive cycles, or alternating indices on consecutive cycles, accumulate exactly as if they had been spaced apart.
- R5: The accumulator holds DEPTH entries. A miss while it is full drops the beat and sets `overflow`. Hits still accumulate while the accumulator is full. `overflow` stays high until the drain of the phase ends.
- R6: After `flush`, one pair is emitted per accepted output handshake. `out_last` is high on the final pair only. Outputs hold steady while `out_ready` is low.
- R7: `in_ready` is low from the edge that accepts `flush` until the edge that transfers the last pair. After that edge `in_ready` is high, `overflow` is low, and the next phase starts with an empty accumulator.
- R8: A flush of an empty accumulator emits nothing, and `in_ready` returns high within two cycles.
- R9: After reset, `in_ready` is 1, `out_valid` is 0 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_idx | input | IDX_W | Output row index of the beat |
| in_a | input | VAL_W | First operand |
| in_b | input | VAL_W | Second operand |
| in_minplus | input | 1 | Semiring select: 0 multiply-accumulate, 1 min-plus |
| flush | input | 1 | Pulse: end the phase and drain (taken while `in_ready` is high) |
| out_valid | output | 1 | Drained pair valid |
| out_ready | input | 1 | Sink takes the drained pair |
| out_idx | output | IDX_W | Index of the drained pair |
| out_val | output | VAL_W | Accumulated value of the drained pair |
| out_last | output | 1 | Final pair of the drain |
| overflow | output | 1 | A beat was dropped because the accumulator was full |

## Verification
The block is driven with four kinds of index stream, and each one isolates a different part of the merge path:
- All-distinct indices exercise only slot allocation and its order.
- A single index repeated on consecutive cycles, and two indices alternating on consecutive cycles, exercise the write-back forwarding path. This path is the only thing separating a correct total from a stale one.
- Min-plus streams with descending and ascending products separate the `min` combine from an overwrite or from an add.
- More distinct indices than slots, followed by hits on stored indices, separate dropping a beat from corrupting an entry.

Random phases over a narrow index range mix hits, misses, gaps and back-pressure. Empty flushes check that the drain handles the empty accumulator.

// File: rtl/spa_pkg.sv
package spa_pkg;
  typedef enum logic [1:0] {
    PH_ACCUM = 2'd0,
    PH_SETTLE = 2'd1,
    PH_DRAIN = 2'd2
  } spa_phase_e;

  localparam logic MODE_MAC = 1'b0;
  localparam logic MODE_MINPLUS = 1'b1;
endpackage

// File: rtl/spa_semiring_mul.sv
module spa_semiring_mul #(
  parameter int VAL_W = 16
) (
  input  logic             minplus,
  input  logic [VAL_W-1:0] a,
  input  logic [VAL_W-1:0] b,
  output logic [VAL_W-1:0] y
);
  logic [2*VAL_W-1:0] full_mul;
  logic [VAL_W:0]     full_add;

  assign full_mul = {{VAL_W{1'b0}}, a} * {{VAL_W{1'b0}}, b};
  assign full_add = {1'b0, a} + {1'b0, b};
  assign y = (minplus == spa_pkg::MODE_MINPLUS) ? full_add[VAL_W-1:0] : full_mul[VAL_W-1:0];
endmodule

// File: rtl/spa_semiring_add.sv
module spa_semiring_add #(
  parameter int VAL_W = 16
) (
  input  logic             minplus,
  input  logic [VAL_W-1:0] acc,
  input  logic [VAL_W-1:0] term,
  output logic [VAL_W-1:0] y
);
  logic [VAL_W:0] sum;

  assign sum = {1'b0, acc} + {1'b0, term};
  assign y = (minplus == spa_pkg::MODE_MINPLUS) ? ((term < acc) ? term : acc) : sum[VAL_W-1:0];
endmodule

// File: rtl/spa_onehot_enc.sv
module spa_onehot_enc #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] onehot,
  output logic [AW-1:0]    addr
);
  always_comb begin
    addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (onehot[i]) addr = addr | AW'(i);
    end
  end
endmodule

// File: rtl/spa_cam_array.sv
module spa_cam_array #(
  parameter int IDX_W = 8,
  parameter int VAL_W = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [IDX_W-1:0] wr_key,
  input  logic [VAL_W-1:0] wr_val,
  input  logic [IDX_W-1:0] srch_key,
  output logic [DEPTH-1:0] hit_vec,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [VAL_W-1:0] rd_val_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [IDX_W-1:0] rd_key_b,
  output logic [VAL_W-1:0] rd_val_b
);
  logic [IDX_W-1:0] key_q [DEPTH];
  logic [VAL_W-1:0] val_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel_we;
    assign sel_we = wr_en && (wr_addr == AW'(g));
    assign hit_vec[g] = vld_q[g] && (key_q[g] == srch_key);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (sel_we) begin
        vld_q[g] <= 1'b1;
      end else if (clear) begin
        vld_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_we) begin
        key_q[g] <= wr_key;
        val_q[g] <= wr_val;
      end
    end
  end

  assign rd_val_a = val_q[rd_addr_a];
  assign rd_key_b = key_q[rd_addr_b];
  assign rd_val_b = val_q[rd_addr_b];

  AST_UNIQUE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)) else $error("duplicate key in CAM"); // R2
endmodule

// File: rtl/spa_cam_merge.sv
module spa_cam_merge #(
  parameter int IDX_W = 8,
  parameter int VAL_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [VAL_W-1:0] in_a,
  input  logic [VAL_W-1:0] in_b,
  input  logic             in_minplus,
  input  logic             flush,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_idx,
  output logic [VAL_W-1:0] out_val,
  output logic             out_last,
  output logic             overflow
);
  import spa_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  spa_phase_e       phase_q;
  logic [PW-1:0]    free_q, rd_q;
  logic             ovf_q;

  // product stage
  logic             s1_v;
  logic [IDX_W-1:0] s1_idx;
  logic [VAL_W-1:0] s1_prod;
  logic             s1_mode;
  logic [VAL_W-1:0] prod_c;

  // write-back stage
  logic             s2_v, s2_hit, s2_mode;
  logic [IDX_W-1:0] s2_idx;
  logic [AW-1:0]    s2_addr;
  logic [VAL_W-1:0] s2_prod, s2_old, s2_comb, s2_res;

  logic [DEPTH-1:0] hit_vec;
  logic [AW-1:0]    enc_addr;
  logic [VAL_W-1:0] arr_val;
  logic             fwd, lk_hit, full, alloc, drop, accept, take_flush, out_fire, drain_done;

  assign in_ready   = (phase_q == PH_ACCUM);
  assign accept     = in_valid && in_ready;
  assign take_flush = flush && in_ready;

  spa_semiring_mul #(.VAL_W(VAL_W)) u_mul (
    .minplus(in_minplus), .a(in_a), .b(in_b), .y(prod_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= accept;
    end
    if (accept) begin
      s1_idx  <= in_idx;
      s1_prod <= prod_c;
      s1_mode <= in_minplus;
    end
  end

  spa_cam_array #(.IDX_W(IDX_W), .VAL_W(VAL_W), .DEPTH(DEPTH)) u_cam (
    .clk(clk), .rst_n(rst_n), .clear(drain_done),
    .wr_en(s2_v), .wr_addr(s2_addr), .wr_key(s2_idx), .wr_val(s2_res),
    .srch_key(s1_idx), .hit_vec(hit_vec),
    .rd_addr_a(enc_addr), .rd_val_a(arr_val),
    .rd_addr_b(rd_q[AW-1:0]), .rd_key_b(out_idx), .rd_val_b(out_val)
  );

  spa_onehot_enc #(.DEPTH(DEPTH)) u_enc (.onehot(hit_vec), .addr(enc_addr));

  // lookup: a pending write-back to the same index wins over the array
  assign fwd    = s2_v && (s2_idx == s1_idx);
  assign lk_hit = fwd || (|hit_vec);
  assign full   = (free_q == PW'(DEPTH));
  assign alloc  = s1_v && !lk_hit && !full;
  assign drop   = s1_v && !lk_hit && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0;
    end else begin
      s2_v <= s1_v && !drop;
    end
    if (s1_v) begin
      s2_idx  <= s1_idx;
      s2_prod <= s1_prod;
      s2_mode <= s1_mode;
      s2_hit  <= lk_hit;
      s2_addr <= fwd ? s2_addr : (lk_hit ? enc_addr : free_q[AW-1:0]);
      s2_old  <= fwd ? s2_res : arr_val;
    end
  end

  spa_semiring_add #(.VAL_W(VAL_W)) u_add (
    .minplus(s2_mode), .acc(s2_old), .term(s2_prod), .y(s2_comb)
  );
  assign s2_res = s2_hit ? s2_comb : s2_prod;

  // drain control
  assign out_valid  = (phase_q == PH_DRAIN);
  assign out_last   = out_valid && (rd_q == free_q - PW'(1));
  assign out_fire   = out_valid && out_ready;
  assign drain_done = out_fire && out_last;
  assign overflow   = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_ACCUM;
      free_q  <= '0;
      rd_q    <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (alloc) free_q <= free_q + PW'(1);
      if (drop) ovf_q <= 1'b1;
      case (phase_q)
        PH_ACCUM: if (take_flush) phase_q <= PH_SETTLE;
        PH_SETTLE: begin
          if (!s1_v && !s2_v) begin
            rd_q <= '0;
            if (free_q == '0) begin
              phase_q <= PH_ACCUM;
              ovf_q   <= 1'b0;
            end else begin
              phase_q <= PH_DRAIN;
            end
          end
        end
        PH_DRAIN: begin
          if (drain_done) begin
            phase_q <= PH_ACCUM;
            free_q  <= '0;
            ovf_q   <= 1'b0;
          end else if (out_fire) begin
            rd_q <= rd_q + PW'(1);
          end
        end
        default: phase_q <= PH_ACCUM;
      endcase
    end
  end

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow) else $error("dropped beat not flagged"); // R5
  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (free_q == $past(free_q) + PW'(1))) else $error("allocation skipped a slot"); // R3
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= PW'(DEPTH)) else $error("free pointer past capacity"); // R5
  AST_NO_INPUT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready) else $error("input open during drain"); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_val) && $stable(out_last)))
    else $error("output changed under back-pressure"); // R6
endmodule

// File: tb/spa_cam_merge_tb.sv
module spa_cam_merge_tb_top;
  localparam int IDX_W = 8;
  localparam int VAL_W = 16;
  localparam int DEPTH = 8;
  localparam longint VMASK = (64'd1 << VAL_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_minplus = 1'b0, flush = 1'b0;
  logic [IDX_W-1:0] in_idx = '0;
  logic [VAL_W-1:0] in_a = '0, in_b = '0;
  logic out_valid, out_ready = 1'b0, out_last, overflow;
  logic [IDX_W-1:0] out_idx;
  logic [VAL_W-1:0] out_val;

  int checks = 0;
  int errors = 0;

  longint m_key [DEPTH];
  longint m_val [DEPTH];
  int m_cnt = 0;
  bit m_ovf = 1'b0;

  always #2 clk = ~clk;

  spa_cam_merge #(.IDX_W(IDX_W), .VAL_W(VAL_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_a(in_a), .in_b(in_b), .in_minplus(in_minplus),
    .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
    .out_idx(out_idx), .out_val(out_val), .out_last(out_last), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint bprod(input bit mp, input longint a, input longint b);
    return mp ? ((a + b) & VMASK) : ((a * b) & VMASK);
  endfunction

  function automatic longint bcomb(input bit mp, input longint acc, input longint t);
    if (mp) return (t < acc) ? t : acc;
    return (acc + t) & VMASK;
  endfunction

  task automatic model_push(input bit mp, input longint idx, input longint a, input longint b);
    longint p = bprod(mp, a, b);
    for (int i = 0; i < m_cnt; i++) begin
      if (m_key[i] == idx) begin
        m_val[i] = bcomb(mp, m_val[i], p);
        return;
      end
    end
    if (m_cnt < DEPTH) begin
      m_key[m_cnt] = idx;
      m_val[m_cnt] = p;
      m_cnt++;
    end else begin
      m_ovf = 1'b1;
    end
  endtask

  // called at a negedge; leaves in_valid high for back-to-back use
  task automatic send(input bit mp, input longint idx, input longint a, input longint b);
    in_minplus = mp;
    in_idx = IDX_W'(idx);
    in_a = VAL_W'(a);
    in_b = VAL_W'(b);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    model_push(mp, idx, a, b);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic flush_and_check(input string tag);
    int n = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit stalled = 1'b0;
    logic [IDX_W-1:0] h_idx;
    logic [VAL_W-1:0] h_val;
    longint g_idx [DEPTH];
    longint g_val [DEPTH];
    idle(3);
    chk(overflow == m_ovf, {"R5 overflow before drain ", tag}, overflow, m_ovf);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(in_ready == 1'b0, {"R7 ready low after flush ", tag}, in_ready, 0);
    if (m_cnt == 0) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && in_ready == 1'b1, {"R8 empty flush ", tag}, {out_valid, in_ready}, 1);
    end else begin
      while (!done && cyc < 400) begin
        out_ready = ($urandom % 4) != 0;
        if (stalled) begin
          chk(out_valid && out_idx == h_idx && out_val == h_val, {"R6 hold under back-pressure ", tag},
              out_val, h_val);
          stalled = 1'b0;
        end
        if (out_valid) begin
          chk(in_ready == 1'b0, {"R7 ready low during drain ", tag}, in_ready, 0);
          if (out_ready) begin
            if (n < DEPTH) begin
              g_idx[n] = out_idx;
              g_val[n] = out_val;
            end
            chk(out_last == (n == m_cnt - 1), {"R6 last flag ", tag}, out_last, (n == m_cnt - 1));
            n++;
            if (out_last) done = 1'b1;
          end else begin
            stalled = 1'b1;
            h_idx = out_idx;
            h_val = out_val;
          end
        end
        @(negedge clk);
        cyc++;
      end
      out_ready = 1'b0;
      chk(n == m_cnt, {"R6 pair count ", tag}, n, m_cnt);
      for (int i = 0; i < m_cnt && i < n; i++) begin
        chk(g_idx[i] == m_key[i], {"R3 drain order ", tag}, g_idx[i], m_key[i]);
        chk(g_val[i] == m_val[i], {"R2 R1 R4 value ", tag}, g_val[i], m_val[i]);
      end
    end
    chk(in_ready == 1'b1 && overflow == 1'b0, {"R7 reopen and clear ", tag}, {in_ready, overflow}, 2);
    m_cnt = 0;
    m_ovf = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 reset ready", in_ready, 1);
    chk(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    chk(overflow == 1'b0, "R9 reset overflow", overflow, 0);

    // R1 R2 R3: multiply-accumulate with hits and distinct indices
    send(0, 3, 5, 7); send(0, 9, 300, 300); send(0, 3, 2, 4); send(0, 20, 1, 1); send(0, 9, 1, 6);
    flush_and_check("mac mix");

    // R4: same index back to back, then alternating indices
    for (int i = 1; i <= 5; i++) send(0, 7, i, 2);
    for (int i = 0; i < 6; i++) send(0, (i % 2) ? 8 : 7, 3, i + 1);
    flush_and_check("back to back");

    // R1 R2: min-plus, descending then ascending products
    send(1, 5, 10, 4); send(1, 5, 3, 2); send(1, 5, 20, 1); send(1, 6, 1, 1); send(1, 6, 40, 40);
    send(1, 5, 65535, 65535);
    flush_and_check("min plus");

    // R5: more distinct indices than slots, then hits while full
    for (int i = 0; i < DEPTH + 3; i++) send(0, 40 + i, i, 3);
    send(0, 42, 10, 10); send(0, 40 + DEPTH + 1, 1, 1); send(0, 47, 2, 2);
    flush_and_check("overflow");

    // R8: empty flush
    flush_and_check("empty");

    // random phases
    for (int ph = 0; ph < 30; ph++) begin
      bit mp = $urandom % 2;
      int len = 1 + ($urandom % 20);
      for (int k = 0; k < len; k++) begin
        send(mp, $urandom % 11, $urandom % 65536, $urandom % 65536);
        if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      end
      flush_and_check($sformatf("random %0d", ph));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule